// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel left/right PCM sample pairs into a three-wire serial audio stream made of a bit clock, a frame clock and a data line. It is always the clock master. It divides the system clock to make the bit clock and fixes each channel slot at 32 bit-clock periods, so one frame is 64 bit clocks long. One shifter-free slot mapper produces four framings: right-justified, left-justified, I2S, and the DSP pulse framing with its A and B variants. It also handles three word lengths and independent polarity inversion of the bit clock and the frame clock.

Sample pairs arrive on a valid/ready handshake and go into a one-entry holding register. At every frame boundary the held pair moves into the frame register that the mapper reads, so a frame never mixes two sample pairs. The configuration inputs are captured at the same boundary, which means a setting can change at runtime without corrupting the frame in flight. When no pair is waiting at a boundary, the block sends the previous pair again and sets a sticky underrun flag.

Top module: `aud_ser_tx`

## Requirements
- R1: With the bit clock not inverted, `bclk_o` is low for CLK_DIV system clocks and then high for CLK_DIV system clocks. A slot is 32 bit-clock periods and a frame is 64. `sdata_o` and `lrclk_o` change only when the internal (non-inverted) bit clock falls.
- R2: Format code 2'b10 is I2S. The left word occupies the half where the frame clock is low (with the frame-clock inversion bit clear), and its MSB is sent in the second bit period of its slot.
- R3: Format code 2'b01 is left-justified. The left word occupies the half where the frame clock is high (with the inversion bit clear), and its MSB is sent in the first bit period of the slot.
- R4: Format code 2'b00 is right-justified. The frame clock is the same as in left-justified mode, and the LSB of each word is sent in the last bit period of its slot.
- R5: Format code 2'b11 is DSP. `lrclk_o` is high only during bit period 0 of the frame. The left word is followed at once by the right word. The left MSB is in period 1 when `cfg_lr_inv_i` is 0 (variant A) and in period 0 when it is 1 (variant B). The inversion bit never changes the frame-clock polarity in this mode.
- R6: Word-length code 2'b00 selects 16 bits, 2'b01 selects 20 bits, and both 2'b10 and 2'b11 select 24 bits. The word is taken from the top bits of the 24-bit input, the low bits are dropped, and every bit period outside the word drives 0.
- R7: When `cfg_bclk_inv_i` is 1, `bclk_o` is the complement of the non-inverted bit clock.
- R8: In formats 2'b00, 2'b01 and 2'b10, `cfg_lr_inv_i` set to 1 inverts `lrclk_o`.
- R9: After reset: format I2S, 20-bit words, no inversion, zero samples, `bclk_o` low, `lrclk_o` low, `sdata_o` low, `smp_ready_o` high and `underrun_o` low.
- R10: Configuration inputs take effect only at a frame boundary. A change in the middle of a frame leaves the rest of that frame unchanged.
- R11: `smp_ready_o` is high only while the holding register is empty. A pair accepted in frame N is sent in frame N+1. While the register is full, `smp_ready_o` is low and any offered pair is ignored.
- R12: If the holding register is empty at a frame boundary, the previous pair is sent again and `underrun_o` goes high. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fmt_i | input | 2 | Frame format code |
| cfg_wl_i | input | 2 | Word-length code |
| cfg_bclk_inv_i | input | 1 | Bit-clock inversion |
| cfg_lr_inv_i | input | 1 | Frame-clock inversion / DSP variant select |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Holding register empty |
| smp_left_i | input | 24 | Left sample, MSB-aligned |
| smp_right_i | input | 24 | Right sample, MSB-aligned |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Serial frame clock |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The stream is checked bit by bit against a bench model over a run of frames. Directed frames go through every format with both settings of the inversion bit, and the remaining frames use random settings. This separates the I2S one-bit delay from left-justified alignment, and DSP variant A from variant B. Using all-ones and random data at 16, 20 and 24 bits shows whether padding and truncation land on the right bit periods, and a right-justified frame catches an LSB that is not at the slot end. Configuration changes in the middle of a frame, double offers while the holding register is full, and frames with no offered pair tell apart frame-aligned capture, dropped data and sample repetition.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SMP_W = 24;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] wl;
    logic       bclk_inv;
    logic       lr_inv;
  } cfg_t;

  localparam cfg_t CFG_RST = '{fmt: FMT_I2S, wl: 2'b01, bclk_inv: 1'b0, lr_inv: 1'b0};

  function automatic int wl_bits(logic [1:0] wl);
    case (wl)
      2'b00:   return 16;
      2'b01:   return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
  parameter int CLK_DIV    = 2,
  parameter int FRAME_BITS = 64,
  localparam int DIV_W     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             bclk_o,
  output logic [POS_W-1:0] pos_o,
  output logic             frame_end_o
);
  logic [DIV_W-1:0] hc_q;
  logic             ph_q;
  logic [POS_W-1:0] pos_q;
  logic             half_end;

  assign half_end    = (hc_q == DIV_W'(CLK_DIV - 1));
  assign frame_end_o = half_end && ph_q && (pos_q == POS_W'(FRAME_BITS - 1));
  assign bclk_o      = ph_q;
  assign pos_o       = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      ph_q  <= 1'b0;
      pos_q <= '0;
    end else if (half_end) begin
      hc_q <= '0;
      ph_q <= ~ph_q;
      if (ph_q) pos_q <= pos_q + 1'b1;
    end else begin
      hc_q <= hc_q + 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (pos_o == '0)); // R1
endmodule

// File: rtl/aud_smp_buf.sv
module aud_smp_buf
  import aud_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic             frame_end_i,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             underrun_o
);
  logic [SMP_W-1:0] hold_l_q, hold_r_q, cur_l_q, cur_r_q;
  logic             full_q, urun_q, accept;

  assign ready_o    = ~full_q;
  assign accept     = valid_i & ~full_q;
  assign left_o     = cur_l_q;
  assign right_o    = cur_r_q;
  assign underrun_o = urun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
      full_q   <= 1'b0;
      urun_q   <= 1'b0;
    end else begin
      if (frame_end_i && full_q) begin
        cur_l_q <= hold_l_q;
        cur_r_q <= hold_r_q;
        full_q  <= 1'b0;
      end else if (accept) begin
        hold_l_q <= left_i;
        hold_r_q <= right_i;
        full_q   <= 1'b1;
      end
      if (frame_end_i && !full_q) urun_q <= 1'b1;
    end
  end

  AST_ACCEPT_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !frame_end_i) |=> !ready_o); // R11
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o); // R12
  AST_FRAME_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> ($stable(left_o) && $stable(right_o))); // R11
endmodule

// File: rtl/aud_slot_map.sv
module aud_slot_map
  import aud_tx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  localparam int SLOT_W   = $clog2(SLOT_BITS),
  localparam int POS_W    = SLOT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  output logic             lr_o,
  output logic             sd_o
);
  int               s, p, n, k, off;
  logic             in_word, right;
  logic [SMP_W-1:0] w, sh;

  always_comb begin
    s       = int'(pos_i[SLOT_W-1:0]);
    p       = int'(pos_i);
    n       = wl_bits(cfg_i.wl);
    right   = pos_i[POS_W-1];
    w       = right ? right_i : left_i;
    in_word = 1'b0;
    k       = 0;
    off     = cfg_i.lr_inv ? 0 : 1;
    lr_o    = 1'b0;
    unique case (cfg_i.fmt)
      FMT_I2S: begin
        lr_o    = right ^ cfg_i.lr_inv;
        in_word = (s >= 1) && (s <= n);
        k       = s - 1;
      end
      FMT_LJ: begin
        lr_o    = ~right ^ cfg_i.lr_inv;
        in_word = (s < n);
        k       = s;
      end
      FMT_RJ: begin
        lr_o    = ~right ^ cfg_i.lr_inv;
        in_word = (s >= SLOT_BITS - n);
        k       = s - (SLOT_BITS - n);
      end
      FMT_DSP: begin
        // lr_inv picks the variant here: MSB delay of one period or none
        lr_o = (p == 0);
        if (p >= off && p < off + n) begin
          w = left_i; k = p - off; in_word = 1'b1;
        end else if (p >= off + n && p < off + 2 * n) begin
          w = right_i; k = p - off - n; in_word = 1'b1;
        end
      end
    endcase
    if (!in_word) k = 0;
    sh   = w << k;
    sd_o = in_word & sh[SMP_W-1];
  end

  AST_DSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.fmt == FMT_DSP && pos_i != '0) |-> !lr_o); // R5
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.fmt == FMT_LJ && int'(pos_i[SLOT_W-1:0]) >= wl_bits(cfg_i.wl)) |-> !sd_o); // R6
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_fmt_i,
  input  logic [1:0]       cfg_wl_i,
  input  logic             cfg_bclk_inv_i,
  input  logic             cfg_lr_inv_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             sdata_o,
  output logic             underrun_o
);
  cfg_t             cfg_in, cfg_q;
  logic             bclk_int, frame_end, lr_int, sd_int;
  logic [POS_W-1:0] pos;
  logic [SMP_W-1:0] cur_l, cur_r;

  assign cfg_in = '{fmt: fmt_e'(cfg_fmt_i), wl: cfg_wl_i,
                    bclk_inv: cfg_bclk_inv_i, lr_inv: cfg_lr_inv_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= CFG_RST;
    else if (frame_end) cfg_q <= cfg_in;
  end

  aud_bclk_gen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_clk (
    .clk_i, .rst_ni, .bclk_o(bclk_int), .pos_o(pos), .frame_end_o(frame_end)
  );

  aud_smp_buf u_buf (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .ready_o(smp_ready_o),
    .left_i(smp_left_i), .right_i(smp_right_i),
    .frame_end_i(frame_end),
    .left_o(cur_l), .right_o(cur_r), .underrun_o(underrun_o)
  );

  aud_slot_map #(.SLOT_BITS(SLOT_BITS)) u_map (
    .clk_i, .rst_ni, .cfg_i(cfg_q), .pos_i(pos),
    .left_i(cur_l), .right_i(cur_r), .lr_o(lr_int), .sd_o(sd_int)
  );

  assign bclk_o  = bclk_int ^ cfg_q.bclk_inv;
  assign lrclk_o = lr_int;
  assign sdata_o = sd_int;

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(cfg_q)); // R10
  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sd_int) || !$stable(lr_int)) |-> $fell(bclk_int)); // R1
endmodule

// File: tb/tb_aud_ser_tx.sv
module tb_aud_ser_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int NFR        = 24;
  localparam int PER_CYC    = 2 * DIV;
  localparam int FRAME_CYC  = 64 * PER_CYC;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] cfg_fmt, cfg_wl;
  logic cfg_bi, cfg_li, valid;
  logic [23:0] din_l, din_r;
  logic ready, bclk, lrclk, sdata, urun;

  int n_chk = 0, n_fail = 0;

  logic [1:0]  c_fmt [NFR];
  logic [1:0]  c_wl  [NFR];
  logic        c_bi  [NFR];
  logic        c_li  [NFR];
  logic [23:0] f_l   [NFR];
  logic [23:0] f_r   [NFR];
  bit          push  [NFR];
  bit          dbl   [NFR];
  bit          exp_un[NFR];

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_ser_tx #(.CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni, .cfg_fmt_i(cfg_fmt), .cfg_wl_i(cfg_wl),
    .cfg_bclk_inv_i(cfg_bi), .cfg_lr_inv_i(cfg_li),
    .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(din_l), .smp_right_i(din_r),
    .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata), .underrun_o(urun)
  );

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic logic bit_at(logic [23:0] w, int k);
    logic [23:0] t;
    t = w << k;
    return t[23];
  endfunction

  function automatic logic exp_lr(logic [1:0] fm, logic li, int pos);
    bit hi;
    hi = (pos >= 32);
    if (fm == 2'b11) return (pos == 0);
    if (fm == 2'b10) return hi ^ li;
    return !hi ^ li;
  endfunction

  function automatic logic exp_sd(logic [1:0] fm, logic [1:0] wl, logic li, int pos,
                                  logic [23:0] l, logic [23:0] r, output bit in_w);
    int n, s, off;
    logic [23:0] w;
    n = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : 24;
    s = pos % 32;
    w = (pos >= 32) ? r : l;
    in_w = 1'b0;
    case (fm)
      2'b10: if (s >= 1 && s <= n) begin in_w = 1'b1; return bit_at(w, s - 1); end
      2'b01: if (s < n) begin in_w = 1'b1; return bit_at(w, s); end
      2'b00: if (s >= 32 - n) begin in_w = 1'b1; return bit_at(w, s - 32 + n); end
      default: begin
        off = li ? 0 : 1;
        if (pos >= off && pos < off + n) begin in_w = 1'b1; return bit_at(l, pos - off); end
        if (pos >= off + n && pos < off + 2 * n) begin in_w = 1'b1; return bit_at(r, pos - off - n); end
      end
    endcase
    return 1'b0;
  endfunction

  function automatic string fmt_tag(logic [1:0] fm);
    case (fm)
      2'b10:   return "R2";
      2'b01:   return "R3";
      2'b00:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic set_cfg(int f, logic [1:0] fm, logic [1:0] wl, logic bi, logic li);
    c_fmt[f] = fm; c_wl[f] = wl; c_bi[f] = bi; c_li[f] = li;
  endtask

  initial begin
    bit [31:0] rv;
    void'($urandom(32'd20240611));
    set_cfg(0, 2'b10, 2'b01, 1'b0, 1'b0);
    f_l[0] = '0; f_r[0] = '0; push[0] = 1'b0; dbl[0] = 1'b0;
    set_cfg(1, 2'b10, 2'b01, 1'b0, 1'b0);
    set_cfg(2, 2'b10, 2'b00, 1'b1, 1'b1);
    set_cfg(3, 2'b01, 2'b10, 1'b0, 1'b0);
    set_cfg(4, 2'b01, 2'b11, 1'b0, 1'b1);
    set_cfg(5, 2'b00, 2'b00, 1'b0, 1'b0);
    set_cfg(6, 2'b00, 2'b10, 1'b1, 1'b1);
    set_cfg(7, 2'b11, 2'b10, 1'b0, 1'b0);
    set_cfg(8, 2'b11, 2'b00, 1'b0, 1'b1);
    set_cfg(9, 2'b11, 2'b01, 1'b1, 1'b1);
    for (int f = 1; f < NFR; f++) begin
      if (f >= 10) begin
        rv = $urandom();
        set_cfg(f, rv[1:0], rv[3:2], rv[4], rv[5]);
      end
      rv = $urandom();
      push[f] = (f < 9) ? 1'b1 : (f == 9) ? 1'b0 : (rv[1:0] != 2'b00);
      dbl[f]  = (f == 3) || (f >= 10 && rv[4:2] == 3'd0);
      if (push[f]) begin
        rv = $urandom(); f_l[f] = rv[23:0];
        rv = $urandom(); f_r[f] = rv[23:0];
        if (f == 5) f_l[f] = 24'hFFFFFF;
        if (f == 6) f_r[f] = 24'hFFFFFF;
      end else begin
        f_l[f] = f_l[f-1]; f_r[f] = f_r[f-1];
      end
    end
    exp_un[0] = 1'b0;
    for (int f = 1; f < NFR; f++) exp_un[f] = exp_un[f-1] | !push[f];

    cfg_fmt = c_fmt[0]; cfg_wl = c_wl[0]; cfg_bi = c_bi[0]; cfg_li = c_li[0];
    valid = 1'b0; din_l = '0; din_r = '0;
    repeat (3) @(negedge clk);
    chk(bclk == 1'b0, "R9", bclk, 1'b0);
    chk(lrclk == 1'b0, "R9", lrclk, 1'b0);
    chk(sdata == 1'b0, "R9", sdata, 1'b0);
    chk(ready == 1'b1, "R9", ready, 1'b1);
    chk(urun == 1'b0, "R9", urun, 1'b0);
    rst_ni = 1'b1;

    for (int k = 0; k < NFR * FRAME_CYC; k++) begin
      int  ph_k, per, pos, f, kl;
      bit  in_w, last_half_chg;
      logic e_lr, e_sd;
      string tg;
      ph_k = k % PER_CYC;
      per  = k / PER_CYC;
      pos  = per % 64;
      f    = per / 64;
      kl   = k % FRAME_CYC;
      if (ph_k == 0 || ph_k == DIV) begin
        chk(bclk == ((ph_k == DIV) ^ c_bi[f]), c_bi[f] ? "R7" : "R1", bclk,
            (ph_k == DIV) ^ c_bi[f]);
        last_half_chg = (pos >= 32) && (f + 1 < NFR) &&
          ({c_fmt[f], c_wl[f], c_li[f]} != {c_fmt[f+1], c_wl[f+1], c_li[f+1]});
        e_lr = exp_lr(c_fmt[f], c_li[f], pos);
        tg = last_half_chg ? "R10" : (c_li[f] && c_fmt[f] != 2'b11) ? "R8" : fmt_tag(c_fmt[f]);
        chk(lrclk === e_lr, tg, lrclk, e_lr);
        e_sd = exp_sd(c_fmt[f], c_wl[f], c_li[f], pos, f_l[f], f_r[f], in_w);
        tg = (f >= 1 && !push[f]) ? "R12" : last_half_chg ? "R10" :
             !in_w ? "R6" : (dbl[f] ? "R11" : fmt_tag(c_fmt[f]));
        chk(sdata === e_sd, tg, sdata, e_sd);
        if (pos == 0 && ph_k == 0) chk(urun === exp_un[f], "R12", urun, exp_un[f]);
      end
      if (f + 1 < NFR) begin
        if (kl == FRAME_CYC / 2) begin
          cfg_fmt = c_fmt[f+1]; cfg_wl = c_wl[f+1]; cfg_bi = c_bi[f+1]; cfg_li = c_li[f+1];
          if (push[f+1]) begin
            chk(ready == 1'b1, "R11", ready, 1'b1);
            valid = 1'b1; din_l = f_l[f+1]; din_r = f_r[f+1];
          end
        end else if (kl == FRAME_CYC / 2 + 1 && valid) begin
          if (dbl[f+1]) begin
            chk(ready == 1'b0, "R11", ready, 1'b0);
            din_l = ~din_l; din_r = ~din_r;
          end else begin
            valid = 1'b0;
          end
        end else if (kl == FRAME_CYC / 2 + 4) begin
          valid = 1'b0;
        end
      end
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule